// File: doc/BRIEF.md
# Chip-Select Qualification Filter

This block sits between the raw, asynchronous active-low chip-select pin of a serial converter port and the logic that reacts to it. It samples the pin on the converter's free-running clock. A new pin level is accepted only once it has stayed unchanged for a setup sample plus a fixed number of further clock edges. Glitches and short pulses therefore never reach the serial port.

The accepted level is presented as `cs_qual_n`. While it is high, the serial port keeps its data input and shift clock gated and its data output floating. Each accepted high-to-low change emits a one-cycle `port_init` pulse, which restarts and realigns the serial port to the host's bit stream. The converter reports that a conversion is in progress on `conv_busy`. If the select was accepted high during that conversion and is then accepted low again before the conversion finishes, the block also emits a one-cycle `conv_abort` pulse. The converter then drops the running conversion and keeps its previous result.

Top module: `cs_qualifier`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `cs_qual_n` is 1 and `port_init` and `conv_abort` are 0.
- R2: A new pin level sampled on HOLD_EDGES+1 consecutive clock edges is accepted. `cs_qual_n` takes that level SYNC_STAGES+HOLD_EDGES edges after the level is first applied: 4 edges with the defaults, SYNC_STAGES=2 and HOLD_EDGES=2.
- R3: A pin level held for HOLD_EDGES edges or fewer is ignored. `cs_qual_n` keeps its value and neither pulse occurs.
- R4: Any change of the pin restarts the stability count. Two short runs of the same level, separated by a one-sample pulse of the other level, are not added together.
- R5: The rule in R2 and R3 applies in the same way to rising levels (deselect), with the same latency.
- R6: `port_init` is high for exactly one cycle, in the same cycle that `cs_qual_n` turns from 1 to 0. It is never high on an accepted rise or while `cs_qual_n` is unchanged.
- R7: Suppose a rise is accepted while `conv_busy` is 1, and the following fall is accepted while `conv_busy` has stayed 1 throughout. Then `conv_abort` is high for exactly one cycle, together with that `port_init` pulse.
- R8: No `conv_abort` occurs in three cases: the select stays low for the whole conversion; the rise was accepted while `conv_busy` was 0; or `conv_busy` went to 0 between the accepted rise and the accepted fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running conversion clock; all sampling on its active edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Raw active-low chip select from the pin, asynchronous |
| conv_busy | input | 1 | High while the converter is performing a conversion |
| cs_qual_n | output | 1 | Qualified active-low select level |
| port_init | output | 1 | One-cycle pulse on each accepted select assertion |
| conv_abort | output | 1 | One-cycle pulse requesting that the running conversion be dropped |

## Verification
A pin change applied before edge 1 first reaches the last synchronizer stage at edge SYNC_STAGES. Counting then finishes at edge SYNC_STAGES+HOLD_EDGES, and on that same edge `cs_qual_n`, `port_init` and `conv_abort` are all registered. All three results therefore appear together, 4 edges after the stimulus with the defaults. The bench drives the pin and `conv_busy` on the falling clock edge. It compares all three outputs on every falling edge against an arithmetic model: the model counts the run length of the sampled pin and delays the decision by SYNC_STAGES-1 edges. Pulse-width sweeps from 1 to 6 edges in both directions, a direct latency count, and the abort scenarios each add explicit checks at the end of the window in which their pulse could occur.

// File: rtl/csq_pkg.sv
package csq_pkg;

    // Registered state of the event stage: abort arming and the two pulses.
    typedef struct packed {
        logic armed;
        logic init;
        logic abort;
    } evt_state_t;

    // Width of a counter that must hold values 0 .. limit-1.
    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic fresh
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl   = st_q.chain[STAGES-1];
    // A level still travelling down the chain: the count must start over.
    assign fresh = st_q.chain[STAGES-1] ^ st_q.chain[STAGES-2];

endmodule

// File: rtl/cs_stability.sv
module cs_stability #(
    parameter int HOLD_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic fresh,
    output logic qual_n,
    output logic fall_now,
    output logic rise_now
);
    localparam int CNT_W = csq_pkg::cnt_width(HOLD_EDGES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_EDGES - 1);

    typedef struct packed {
        logic             qual;
        logic [CNT_W-1:0] cnt;
    } stab_state_t;

    stab_state_t st_d, st_q;
    logic        take;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if ((lvl == st_q.qual) || fresh) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            take      = 1'b1;
            st_d.qual = lvl;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.qual <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign qual_n   = st_q.qual;
    assign fall_now = take & ~lvl;
    assign rise_now = take &  lvl;

endmodule

// File: rtl/cs_event.sv
module cs_event (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_now,
    input  logic rise_now,
    input  logic busy,
    output logic init_pulse,
    output logic abort_pulse
);
    import csq_pkg::*;

    evt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.init  = fall_now;
        st_d.abort = fall_now & st_q.armed & busy;
        if (!busy) begin
            st_d.armed = 1'b0;
        end else if (rise_now) begin
            st_d.armed = 1'b1;
        end else if (st_d.abort) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_pulse  = st_q.init;
    assign abort_pulse = st_q.abort;

endmodule

// File: rtl/cs_qualifier.sv
module cs_qualifier #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_EDGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic conv_busy,
    output logic cs_qual_n,
    output logic port_init,
    output logic conv_abort
);
    logic sync_lvl;
    logic sync_fresh;
    logic fall_now;
    logic rise_now;

    cs_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cs_n_in),
        .lvl   (sync_lvl),
        .fresh (sync_fresh)
    );

    cs_stability #(
        .HOLD_EDGES (HOLD_EDGES)
    ) u_stab (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (sync_lvl),
        .fresh    (sync_fresh),
        .qual_n   (cs_qual_n),
        .fall_now (fall_now),
        .rise_now (rise_now)
    );

    cs_event u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_now    (fall_now),
        .rise_now    (rise_now),
        .busy        (conv_busy),
        .init_pulse  (port_init),
        .abort_pulse (conv_abort)
    );

endmodule

// File: rtl/cs_qualifier_chk.sv
module cs_qualifier_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_qual_n,
    input logic port_init,
    input logic conv_abort,
    input logic conv_busy,
    input logic sync_lvl
);
    // R6
    init_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_init |-> (!cs_qual_n && $past(cs_qual_n)));

    // R6
    fall_has_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_qual_n) |-> port_init);

    // R2
    qual_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_qual_n) |-> (cs_qual_n == $past(sync_lvl)));

    // R7
    abort_with_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> port_init);

    // R7
    abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> $past(conv_busy));

    // R7
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |=> !conv_abort);

endmodule

bind cs_qualifier cs_qualifier_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_qual_n  (cs_qual_n),
    .port_init  (port_init),
    .conv_abort (conv_abort),
    .conv_busy  (conv_busy),
    .sync_lvl   (sync_lvl)
);

// File: tb/sim_cs_qualifier.sv
module sim_cs_qualifier;
    localparam int SYNC = 2;
    localparam int HOLD = 2;
    localparam int D    = SYNC - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_in = 1'b1;
    logic conv_busy = 1'b0;
    logic cs_qual_n, port_init, conv_abort;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    cs_qualifier #(.SYNC_STAGES(SYNC), .HOLD_EDGES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .conv_busy(conv_busy),
        .cs_qual_n(cs_qual_n), .port_init(port_init), .conv_abort(conv_abort)
    );

    // Reference model: run length of pin samples, decision delayed D edges.
    logic m_last = 1'b1;
    int   m_run  = HOLD + 1;
    logic m_iq   = 1'b1;
    logic m_armed = 1'b0;
    logic pq [D];
    logic pf [D];
    logic pr [D];
    logic m_qual = 1'b1, m_init = 1'b0, m_abort = 1'b0;

    always @(posedge clk) begin
        logic nf, nr, eq, ef, er;
        if (!rst_n) begin
            m_last = 1'b1; m_run = HOLD + 1; m_iq = 1'b1; m_armed = 1'b0;
            for (int i = 0; i < D; i++) begin pq[i] = 1'b1; pf[i] = 1'b0; pr[i] = 1'b0; end
            m_qual = 1'b1; m_init = 1'b0; m_abort = 1'b0;
        end else begin
            if (cs_n_in == m_last) begin
                if (m_run < 1000) m_run = m_run + 1;
            end else begin
                m_run = 1;
            end
            m_last = cs_n_in;
            nf = 1'b0; nr = 1'b0;
            if (m_run >= HOLD + 1 && cs_n_in != m_iq) begin
                m_iq = cs_n_in; nf = ~m_iq; nr = m_iq;
            end
            eq = pq[D-1]; ef = pf[D-1]; er = pr[D-1];
            for (int i = D - 1; i > 0; i--) begin pq[i] = pq[i-1]; pf[i] = pf[i-1]; pr[i] = pr[i-1]; end
            pq[0] = m_iq; pf[0] = nf; pr[0] = nr;
            m_qual  = eq;
            m_init  = ef;
            m_abort = ef & m_armed & conv_busy;
            if (!conv_busy) m_armed = 1'b0;
            else if (er) m_armed = 1'b1;
            else if (m_abort) m_armed = 1'b0;
        end
    end

    logic seen_init, seen_abort, seen_low, seen_high;

    task automatic check(input string tag);
        total++;
        if ({cs_qual_n, port_init, conv_abort} !== {m_qual, m_init, m_abort}) begin
            fails++;
            $display("FAIL %s: qual/init/abort=%b%b%b expected %b%b%b at %0t",
                     tag, cs_qual_n, port_init, conv_abort, m_qual, m_init, m_abort, $time);
        end
        if (port_init)  seen_init  = 1'b1;
        if (conv_abort) seen_abort = 1'b1;
        if (!cs_qual_n) seen_low   = 1'b1;
        if (cs_qual_n)  seen_high  = 1'b1;
    endtask

    task automatic expect_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic expect_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic cs, input logic busy, input string tag);
        @(negedge clk);
        check(tag);
        cs_n_in   = cs;
        conv_busy = busy;
    endtask

    task automatic clear_seen();
        seen_init = 1'b0; seen_abort = 1'b0; seen_low = 1'b0; seen_high = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int lat;
        clear_seen();
        repeat (3) @(negedge clk);
        // R1: reset state
        expect_bit("R1 qual", cs_qual_n, 1'b1);
        expect_bit("R1 init", port_init, 1'b0);
        expect_bit("R1 abort", conv_abort, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_bit("R1 after release", {cs_qual_n, port_init, conv_abort} == 3'b100, 1'b1);

        // R2: latency of an accepted fall
        repeat (6) cyc(1, 0, "R2");
        cyc(0, 0, "R2");
        lat = 0;
        for (int k = 1; k <= 10; k++) begin
            cyc(0, 0, "R2");
            if (!cs_qual_n && lat == 0) lat = k;
        end
        expect_int("R2 fall latency", lat, SYNC + HOLD);

        // R5: latency of an accepted rise
        cyc(1, 0, "R5");
        lat = 0;
        for (int k = 1; k <= 10; k++) begin
            cyc(1, 0, "R5");
            if (cs_qual_n && lat == 0) lat = k;
        end
        expect_int("R5 rise latency", lat, SYNC + HOLD);

        // R2/R3/R6: low pulse width sweep from a settled high
        for (int w = 1; w <= 6; w++) begin
            repeat (8) cyc(1, 0, "R3/R6");
            clear_seen();
            repeat (w) cyc(0, 0, "R2/R3");
            repeat (10) cyc(1, 0, "R2/R3/R6");
            expect_bit(w > HOLD ? "R2 low pulse accepted" : "R3 low pulse ignored",
                       seen_init, w > HOLD);
            expect_bit(w > HOLD ? "R2 qual dipped" : "R3 qual held",
                       seen_low, w > HOLD);
        end

        // R5/R3/R6: high pulse width sweep from a settled low
        for (int w = 1; w <= 6; w++) begin
            repeat (8) cyc(0, 0, "R5/R6");
            clear_seen();
            repeat (w) cyc(1, 0, "R5/R3");
            repeat (10) cyc(0, 0, "R5/R3/R6");
            expect_bit(w > HOLD ? "R5 high pulse accepted" : "R3 high pulse ignored",
                       seen_high, w > HOLD);
            expect_bit("R6 init only after accepted rise", seen_init, w > HOLD);
        end

        // R4: broken runs are not summed
        repeat (8) cyc(1, 0, "R4");
        clear_seen();
        repeat (2) cyc(0, 0, "R4");
        cyc(1, 0, "R4");
        repeat (2) cyc(0, 0, "R4");
        repeat (10) cyc(1, 0, "R4");
        expect_bit("R4 split runs ignored", seen_low, 1'b0);
        clear_seen();
        repeat (2) cyc(0, 0, "R4");
        cyc(1, 0, "R4");
        repeat (3) cyc(0, 0, "R4");
        repeat (8) cyc(0, 0, "R4");
        expect_bit("R4 full run after restart accepted", seen_init, 1'b1);

        // R7: rise and fall both accepted during one conversion
        repeat (8) cyc(0, 1, "R7");
        clear_seen();
        repeat (5) cyc(1, 1, "R7");
        repeat (8) cyc(0, 1, "R7");
        expect_bit("R7 abort raised", seen_abort, 1'b1);
        repeat (4) cyc(0, 0, "R7");

        // R8: rise accepted before the conversion started
        repeat (5) cyc(1, 0, "R8");
        clear_seen();
        repeat (8) cyc(0, 1, "R8");
        expect_bit("R8 rise before busy", seen_abort, 1'b0);
        expect_bit("R8 init still given", seen_init, 1'b1);
        repeat (4) cyc(0, 0, "R8");

        // R8: conversion ended between rise and fall
        clear_seen();
        repeat (5) cyc(1, 1, "R8");
        repeat (2) cyc(1, 0, "R8");
        repeat (8) cyc(0, 1, "R8");
        expect_bit("R8 busy dropped in between", seen_abort, 1'b0);

        // R8: select held low through a whole conversion
        clear_seen();
        repeat (6) cyc(0, 1, "R8");
        repeat (6) cyc(0, 0, "R8");
        expect_bit("R8 low throughout", seen_abort | seen_init, 1'b0);

        cyc(0, 0, "R8");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule